// File: doc/BRIEF.md
# Time-Triggered Transmission Timer

This block is the time base that a CAN controller uses for time-triggered transmission. It holds a 16-bit local-time counter. The counter advances on a count tick, and the tick comes either from a power-of-two division of the system clock or from an external pulse that arrives once per nominal CAN bit. Cycle time is derived from local time: it is local time minus a reference offset, and the offset captures the current local time whenever the reference-message strobe pulses.

There are three 16-bit compare registers. One watches local time and two watch cycle time. A match sets a sticky status flag, and a counter wrap sets one more flag. Each flag has its own enable bit, and the enabled flags drive a single interrupt line. The local-time compare can also restart the counter, which turns the block into a periodic timer.

Software reaches the block through a simple port of 16-bit registers. Writes are strobed and take effect at the clock edge. Reads are combinational. Address map: 0 control, 1 status, 2 local time, 3 local compare, 4 cycle compare A, 5 cycle compare B, 6 reference offset (read only), 7 cycle time (read only).

Top module: `cantt_timer`

## Requirements
- R1: After reset, every register reads zero, the prescaler is zero and `irq` is low.
- R2: Control bit 0 is the run enable. Control bits 3:1 select the tick source. For a code n from 0 to 6, local time advances once every 2^n system clocks. Code 7 advances local time once for each clock in which `bitTick` is high. With run clear, local time holds.
- R3: Writing address 2 loads local time, and this load wins over a tick in the same cycle. The write also restarts the prescaler, so the next advance comes a full division period after the write.
- R4: When local time advances from 0xFFFF it goes to 0x0000 and sets status bit 3 (overflow). This does not apply when the clear-on-match restart of R5 takes place on that tick.
- R5: Control bit 4 enables clear-on-match. When it is set and local time equals the local compare on a tick, local time goes to 0 instead of advancing, so the period is compare+1 ticks.
- R6: Status bit 0 sets on each tick whose new local-time value equals the local compare register (address 3).
- R7: Address 7 reads local time minus the offset. A pulse on `refStrobe` loads the offset (address 6) with the local time at that clock.
- R8: Status bits 1 and 2 set on each tick whose new cycle time equals compare A or compare B. The cycle time is taken with the offset held before that clock.
- R9: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A flag that sets in the same cycle as its clear stays set.
- R10: Control bits 11:8 enable status bits 3:0 one for one. `irq` is high exactly when an enabled status bit is set. Control reads back only bits 0 to 4 and 8 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr (combinational) |
| bitTick | input | 1 | One-clock pulse per nominal CAN bit |
| refStrobe | input | 1 | Reference-message pulse; captures the offset |
| irq | output | 1 | Interrupt request |

## Verification
Each register write, tick, capture and flag set shows up at the ports one clock edge after the cycle that caused it, and `regRdata` and `irq` then follow combinationally. The first advance after a run or counter write arrives 2^n clocks later. The bench steps a behavioural model on the same edge as the design, drives inputs on the falling edge and samples 2 ns after the rising edge. On every clock it compares `irq` and the register read back at the current address against the model. This makes an off-by-one in the prescaler, the restart or a flag show up in the exact cycle where it first goes wrong.

// File: rtl/cantt_pkg.sv
package cantt_pkg;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_REG  = 1 << ADDR_W;
  localparam int SEL_W    = 3;
  localparam int MAX_SHIFT = (1 << SEL_W) - 2;
  localparam int PSC_W    = MAX_SHIFT;
  localparam int NUM_CMP  = 3;
  localparam int NUM_FLAG = NUM_CMP + 1;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CNT  = 2;
  localparam int ADDR_CMP0 = 3;
  localparam int ADDR_OFF  = 6;
  localparam int ADDR_CYC  = 7;

  localparam int RUN_BIT  = 0;
  localparam int SEL_LSB  = 1;
  localparam int CLR_BIT  = 4;
  localparam int EN_LSB   = 8;
  localparam logic [SEL_W-1:0] SEL_BITTICK = '1;
  localparam logic [CNT_W-1:0] CTRL_MASK   = 16'h0F1F;

  localparam int FLG_LOC = 0;
  localparam int FLG_OVF = NUM_CMP;

  typedef struct packed {
    logic                tick;
    logic                cntLoad;
    logic [NUM_CMP-1:0]  cmpLoad;
    logic [NUM_FLAG-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/cantt_ctrl.sv
module cantt_ctrl
  import cantt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  logic              bitTick,
  output logic [CNT_W-1:0]  ctrlReg,
  output strobe_t           strb
);
  logic [NUM_REG-1:0] wrSel;
  logic [SEL_W-1:0]   sel;
  logic               run;
  logic               useBit;
  logic [PSC_W-1:0]   pscCnt;
  logic [PSC_W-1:0]   divLast;
  logic               pscHit;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_dec
    assign wrSel[g] = regWe && (regAddr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ctrlReg <= '0;
    else if (wrSel[ADDR_CTRL]) ctrlReg <= regWdata & CTRL_MASK;
  end

  assign sel     = ctrlReg[SEL_LSB +: SEL_W];
  assign run     = ctrlReg[RUN_BIT];
  assign useBit  = (sel == SEL_BITTICK);
  assign divLast = (PSC_W'(1) << sel) - PSC_W'(1);
  assign pscHit  = (pscCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pscCnt <= '0;
    else if (wrSel[ADDR_CNT]) pscCnt <= '0;
    else if (run && !useBit)  pscCnt <= pscHit ? '0 : pscCnt + PSC_W'(1);
  end

  always_comb begin
    strb.tick    = run && (useBit ? bitTick : pscHit);
    strb.cntLoad = wrSel[ADDR_CNT];
    strb.cmpLoad = wrSel[ADDR_CMP0 +: NUM_CMP];
    strb.flagClr = wrSel[ADDR_STAT] ? regWdata[NUM_FLAG-1:0] : '0;
  end
endmodule

// File: rtl/cantt_dpath.sv
module cantt_dpath
  import cantt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [CNT_W-1:0]    regWdata,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                refStrobe,
  input  logic [CNT_W-1:0]    ctrlReg,
  output logic [CNT_W-1:0]    count,
  output logic [CNT_W-1:0]    offset,
  output logic [CNT_W-1:0]    cmpLocal,
  output logic [NUM_FLAG-1:0] flags,
  output logic [CNT_W-1:0]    regRdata,
  output logic                irq
);
  logic [CNT_W-1:0]    cmpReg [NUM_CMP];
  logic [CNT_W-1:0]    nextCnt;
  logic [CNT_W-1:0]    nextCyc;
  logic                clearNow;
  logic                advance;
  logic [NUM_FLAG-1:0] setVec;

  assign clearNow = ctrlReg[CLR_BIT] && (count == cmpReg[0]);
  assign nextCnt  = clearNow ? '0 : count + CNT_W'(1);
  assign nextCyc  = nextCnt - offset;
  assign advance  = strb.tick && !strb.cntLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strb.cntLoad) count <= regWdata;
    else if (strb.tick)    count <= nextCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          offset <= '0;
    else if (refStrobe) offset <= count;
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cmpReg[g] <= '0;
      else if (strb.cmpLoad[g]) cmpReg[g] <= regWdata;
    end
    if (g == FLG_LOC) begin : g_loc
      assign setVec[g] = advance && (nextCnt == cmpReg[g]);
    end else begin : g_cyc
      assign setVec[g] = advance && (nextCyc == cmpReg[g]);
    end
  end

  assign setVec[FLG_OVF] = advance && !clearNow && (count == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~strb.flagClr) | setVec;
  end

  assign cmpLocal = cmpReg[0];
  assign irq      = |(flags & ctrlReg[EN_LSB +: NUM_FLAG]);

  always_comb begin
    case (int'(regAddr))
      ADDR_CTRL: regRdata = ctrlReg;
      ADDR_STAT: regRdata = CNT_W'(flags);
      ADDR_CNT:  regRdata = count;
      ADDR_OFF:  regRdata = offset;
      ADDR_CYC:  regRdata = count - offset;
      default:   regRdata = cmpReg[int'(regAddr) - ADDR_CMP0];
    endcase
  end
endmodule

// File: rtl/cantt_timer.sv
module cantt_timer
  import cantt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic              bitTick,
  input  logic              refStrobe,
  output logic              irq
);
  strobe_t             strb;
  logic [CNT_W-1:0]    ctrlReg;
  logic [CNT_W-1:0]    count;
  logic [CNT_W-1:0]    offset;
  logic [CNT_W-1:0]    cmpLocal;
  logic [NUM_FLAG-1:0] flags;

  cantt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .bitTick(bitTick), .ctrlReg(ctrlReg), .strb(strb)
  );

  cantt_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .regAddr(regAddr), .refStrobe(refStrobe), .ctrlReg(ctrlReg),
    .count(count), .offset(offset), .cmpLocal(cmpLocal), .flags(flags),
    .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: rtl/cantt_timer_chk.sv
module cantt_timer_chk
  import cantt_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [CNT_W-1:0]    regWdata,
  input logic                refStrobe,
  input strobe_t             strb,
  input logic [CNT_W-1:0]    ctrlReg,
  input logic [CNT_W-1:0]    count,
  input logic [CNT_W-1:0]    offset,
  input logic [CNT_W-1:0]    cmpLocal,
  input logic [NUM_FLAG-1:0] flags,
  input logic                irq
);
  logic restart;
  assign restart = ctrlReg[CLR_BIT] && (count == cmpLocal);

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[RUN_BIT] && !strb.cntLoad) |=> $stable(count));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntLoad && !restart) |=> (count == $past(count) + CNT_W'(1)));

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(ADDR_CNT)) |=> (count == $past(regWdata)));

  a_r4_wrap_flags: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntLoad && !restart && count == '1) |=> (count == '0 && flags[FLG_OVF]));

  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntLoad && restart) |=> (count == '0));

  a_r7_offset_capture: assert property (@(posedge clk) disable iff (!rstN)
    refStrobe |=> (offset == $past(count)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FLG_LOC] && !strb.flagClr[FLG_LOC]) |=> flags[FLG_LOC]);

  a_r10_irq_quiet_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[EN_LSB +: NUM_FLAG] == '0) |-> !irq);
endmodule

bind cantt_timer cantt_timer_chk u_chk (.*);

// File: tb/cantt_timer_tb.sv
module cantt_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        bitTick = 1'b0;
  logic        refStrobe = 1'b0;
  logic        irq;

  int    nTests = 0;
  int    nFail  = 0;
  string curReq = "R1";
  bit    done   = 1'b0;

  always #4 clk = ~clk;

  cantt_timer u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .bitTick(bitTick),
    .refStrobe(refStrobe), .irq(irq)
  );

  // behavioural reference
  int          mPc;
  logic [15:0] mCtrl, mCnt, mOff;
  logic [15:0] mCmp [3];
  logic [3:0]  mFlg;

  always @(posedge clk) begin
    int          sel, divn;
    bit          tk, ld, rs;
    logic [15:0] nxt, cyc;
    logic [3:0]  setv, clrv;
    if (!rstN) begin
      mPc = 0; mCtrl = 0; mCnt = 0; mOff = 0; mFlg = 0;
      foreach (mCmp[i]) mCmp[i] = 0;
    end else begin
      sel  = int'(mCtrl[3:1]);
      divn = 1 << sel;
      tk   = mCtrl[0] && ((sel == 7) ? bitTick : (mPc >= divn - 1));
      ld   = regWe && regAddr == 3'd2;
      rs   = mCtrl[4] && (mCnt == mCmp[0]);
      nxt  = rs ? 16'd0 : mCnt + 16'd1;
      cyc  = nxt - mOff;
      setv = 4'd0;
      if (tk && !ld) begin
        if (nxt == mCmp[0]) setv[0] = 1'b1;
        if (cyc == mCmp[1]) setv[1] = 1'b1;
        if (cyc == mCmp[2]) setv[2] = 1'b1;
        if (!rs && mCnt == 16'hFFFF) setv[3] = 1'b1;
      end
      clrv = (regWe && regAddr == 3'd1) ? regWdata[3:0] : 4'd0;
      mFlg = (mFlg & ~clrv) | setv;
      if (ld) mPc = 0;
      else if (mCtrl[0] && sel != 7) mPc = (mPc >= divn - 1) ? 0 : mPc + 1;
      if (refStrobe) mOff = mCnt;
      if (ld) mCnt = regWdata;
      else if (tk) mCnt = nxt;
      if (regWe && regAddr == 3'd0) mCtrl = regWdata & 16'h0F1F;
      if (regWe && regAddr >= 3'd3 && regAddr <= 3'd5) mCmp[int'(regAddr) - 3] = regWdata;
    end
  end

  function automatic logic [15:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd1: return {12'd0, mFlg};
      3'd2: return mCnt;
      3'd6: return mOff;
      3'd7: return mCnt - mOff;
      default: return mCmp[int'(a) - 3];
    endcase
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      check("irq", {15'd0, irq}, {15'd0, |(mFlg & mCtrl[11:8])});
      check($sformatf("read addr %0d", regAddr), regRdata, modelRead(regAddr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [2:0] watchA);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0; regAddr = watchA;
  endtask

  task automatic watch(input logic [2:0] a, input int n);
    regAddr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRef();
    @(negedge clk); refStrobe = 1'b1;
    @(negedge clk); refStrobe = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: everything zero after reset
    curReq = "R1";
    for (int a = 0; a < 8; a++) watch(3'(a), 1);
    check("post-reset irq", {15'd0, irq}, 16'd0);

    // R2: divide by 4, then by 1, then bit ticks, then stopped
    curReq = "R2";
    wr(3'd0, 16'h0005, 3'd2); watch(3'd2, 40);
    wr(3'd0, 16'h0001, 3'd2); watch(3'd2, 20);
    wr(3'd0, 16'h000F, 3'd2);
    for (int i = 0; i < 30; i++) begin
      bitTick = (i % 3 == 0) || (i % 7 == 0);
      @(negedge clk);
    end
    bitTick = 1'b0;
    wr(3'd0, 16'h000C, 3'd2); watch(3'd2, 15);
    wr(3'd0, 16'h000D, 3'd2); watch(3'd2, 300);

    // R3: counter write mid prescale, with a tick possibly colliding
    curReq = "R3";
    wr(3'd0, 16'h0007, 3'd2); watch(3'd2, 5);
    wr(3'd2, 16'h1234, 3'd2); watch(3'd2, 25);
    wr(3'd0, 16'h0001, 3'd2);
    wr(3'd2, 16'h0100, 3'd2); watch(3'd2, 4);

    // R4 and R10: wrap with overflow enabled
    curReq = "R4";
    wr(3'd0, 16'h0801, 3'd1);
    wr(3'd2, 16'hFFF8, 3'd1); watch(3'd1, 12);
    watch(3'd2, 2);

    // R9: clear and same-cycle set
    curReq = "R9";
    wr(3'd1, 16'h0008, 3'd1); watch(3'd1, 3);
    wr(3'd2, 16'hFFFF, 3'd1);
    wr(3'd1, 16'h0008, 3'd1); watch(3'd1, 3);
    wr(3'd1, 16'h0000, 3'd1); watch(3'd1, 2);
    wr(3'd1, 16'h000F, 3'd1); watch(3'd1, 2);

    // R5 and R6: periodic restart at compare 9
    curReq = "R5";
    wr(3'd3, 16'd9, 3'd2);
    wr(3'd0, 16'h0111, 3'd2);
    wr(3'd2, 16'd0, 3'd2); watch(3'd2, 35);
    curReq = "R6";
    watch(3'd1, 12);
    wr(3'd1, 16'h0001, 3'd1); watch(3'd1, 12);
    wr(3'd0, 16'h0103, 3'd1);
    wr(3'd3, 16'd0, 3'd2);
    wr(3'd2, 16'hFFFD, 3'd1); watch(3'd1, 20);

    // R7: reference capture and cycle time
    curReq = "R7";
    wr(3'd0, 16'h0001, 3'd7);
    wr(3'd2, 16'd100, 3'd7); watch(3'd7, 5);
    pulseRef(); watch(3'd6, 3); watch(3'd7, 10);
    pulseRef(); watch(3'd7, 6);

    // R8: cycle compares A and B
    curReq = "R8";
    wr(3'd4, 16'd5, 3'd1);
    wr(3'd5, 16'd12, 3'd1);
    wr(3'd0, 16'h0601, 3'd1);
    wr(3'd1, 16'h000F, 3'd1);
    pulseRef(); watch(3'd1, 20);
    wr(3'd1, 16'h0002, 3'd1); watch(3'd1, 4);
    pulseRef(); watch(3'd1, 20);

    // R10: enable gating of irq
    curReq = "R10";
    wr(3'd0, 16'hFFFF, 3'd0); watch(3'd0, 3);
    wr(3'd0, 16'h0000, 3'd1); watch(3'd1, 3);
    wr(3'd0, 16'h0400, 3'd1); watch(3'd1, 3);
    wr(3'd1, 16'h000F, 3'd1); watch(3'd1, 3);
    finishRun();
  end
endmodule